// File: doc/BRIEF.md
# Selectable-Source Toggle Rate Generator

This block drives a slow square wave to an LCD panel. The level inverts after a programmable number of display timing strobes. The counted strobe is either the frame strobe or the line strobe, chosen at run time. Software programs the block through one 8-bit control register. Bit 7 of that register picks the source, and bits 6..0 hold a rate code. The output inverts once on every code+1 selected strobes, so the half-period is anywhere from 1 to 128 strobes.

Both strobes are single-cycle pulses that are synchronous to the system clock. A small state machine counts the strobes:

- **ST_IDLE**: the event counter is zero.
- **ST_COUNT**: a partial count is in progress.

The transitions are:

- **idle_flip**: a strobe arrives in ST_IDLE while the code is 0. The output toggles and the state stays ST_IDLE.
- **idle_start**: a strobe arrives in ST_IDLE while the code is not 0. The counter becomes 1 and the state moves to ST_COUNT.
- **count_step**: a strobe arrives in ST_COUNT while the counter is below the code. The counter increments.
- **count_wrap**: a strobe arrives in ST_COUNT while the counter equals the code. The output toggles, the counter reloads to 0 and the state returns to ST_IDLE.
- **write_clear**: any register write returns the machine to ST_IDLE with a zero count. It takes priority over all the transitions above.

Top module: `toggle_rate_gen`

## Requirements
- R1: During and after reset, `rd_data` reads 0x00 and `tog_out` is low.
- R2: A write stores all 8 bits of `wr_data`. From the following cycle, `rd_data` returns that value.
- R3: When bit 7 of the register is 0, only `frame_stb` pulses are counted. `line_stb` pulses do not change `tog_out` or the count.
- R4: When bit 7 of the register is 1, only `line_stb` pulses are counted. `frame_stb` pulses do not change `tog_out` or the count.
- R5: With rate code C in bits 6..0, `tog_out` inverts on every (C+1)-th counted strobe. It changes one cycle after the clock edge that samples that strobe. C=0 inverts on every strobe, and C=127 inverts on every 128th strobe.
- R6: A write clears the strobe count and leaves `tog_out` unchanged. A selected strobe that falls in the same cycle as a write is discarded.
- R7: `tog_out` changes only after a cycle that has a selected strobe and no write.
- R8: A new source selection applies from the next strobe of the newly chosen source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit 7 selects the source (0 frame, 1 line), bits 6..0 hold the rate code |
| rd_data | output | 8 | Current register contents |
| frame_stb | input | 1 | Single-cycle frame strobe |
| line_stb | input | 1 | Single-cycle line strobe |
| tog_out | output | 1 | Toggle output to the panel |

## Verification
The assertions check the following on every cycle:

- The count never exceeds the code, and ST_IDLE always holds a zero count.
- A write clears the count and keeps the output level.
- The output holds whenever no selected strobe is counted.
- A wrap always inverts the output.
- The register reads back what was written.

Only the bench's scenarios can show the exact strobe number at which each toggle lands, across every rate code for frame strobes and a subset for line strobes. The same is true of correct handling of the unselected strobe, of a strobe that coincides with a write, and of a source switch in the middle of a count.

// File: rtl/trg_pkg.sv
package trg_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } trg_state_e;

endpackage

// File: rtl/trg_ctrl_reg.sv
module trg_ctrl_reg #(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end
    end

    // R2: written value is visible on the next cycle
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q == $past(wr_data)));

    // R2: register holds its value without a write
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/trg_src_sel.sv
module trg_src_sel #(
    parameter int N_SRC = 2,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] src_stb,
    input  logic [SEL_W-1:0] sel,
    output logic             evt
);

    logic [N_SRC-1:0] gated;

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign gated[g] = src_stb[g] && (sel == SEL_W'(g));
    end

    assign evt = |gated;

endmodule

// File: rtl/trg_rate_fsm.sv
module trg_rate_fsm
    import trg_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              evt,
    input  logic [CODE_W-1:0] code,
    output logic              tog_out
);

    trg_state_e        state_q, state_d;
    logic [CODE_W-1:0] cnt_q, cnt_d;
    logic              flip;

    // State and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        flip    = 1'b0;
        if (clr) begin
            state_d = ST_IDLE;                  // write_clear
            cnt_d   = '0;
        end else if (evt) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (code == '0) begin
                        flip = 1'b1;            // idle_flip
                    end else begin
                        state_d = ST_COUNT;     // idle_start
                        cnt_d   = CODE_W'(1);
                    end
                end
                ST_COUNT: begin
                    if (cnt_q >= code) begin
                        flip    = 1'b1;         // count_wrap
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CODE_W'(1); // count_step
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_out <= 1'b0;
        end else if (flip) begin
            tog_out <= ~tog_out;
        end
    end

    // R5: partial count never passes the code
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= code);

    // R5: idle state always carries a zero count
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cnt_q == '0));

    // R5: a strobe at the terminal count inverts the output
    p_wrap_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clr && cnt_q == code) |=> (tog_out != $past(tog_out)));

    // R6: a write clears the count and keeps the level
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && $stable(tog_out)));

    // R7: no counted strobe, no change
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt && !clr) |=> $stable(tog_out));

endmodule

// File: rtl/toggle_rate_gen.sv
module toggle_rate_gen #(
    parameter int CODE_W = 7,
    localparam int CTRL_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              frame_stb,
    input  logic              line_stb,
    output logic              tog_out
);

    logic [CTRL_W-1:0] ctrl_q;
    logic              evt;

    trg_ctrl_reg #(.CTRL_W(CTRL_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    // source index 0 = frame, 1 = line
    trg_src_sel #(.N_SRC(2)) u_sel (
        .src_stb ({line_stb, frame_stb}),
        .sel     (ctrl_q[CTRL_W-1]),
        .evt     (evt)
    );

    trg_rate_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wr_en),
        .evt     (evt),
        .code    (ctrl_q[CODE_W-1:0]),
        .tog_out (tog_out)
    );

    assign rd_data = ctrl_q;

    // R3: in frame mode, absent a frame strobe the output holds
    p_frame_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTRL_W-1] && !frame_stb) |=> $stable(tog_out));

    // R4: in line mode, absent a line strobe the output holds
    p_line_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_W-1] && !line_stb) |=> $stable(tog_out));

endmodule

// File: tb/test_toggle_rate_gen.sv
module test_toggle_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       frame_stb = 1'b0;
    logic       line_stb = 1'b0;
    logic       tog_out;

    int checks = 0;
    int fails = 0;

    // reference model state
    logic [7:0] m_reg = '0;
    int         m_cnt = 0;
    logic       m_tog = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    toggle_rate_gen i_toggle_rate_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .frame_stb (frame_stb),
        .line_stb  (line_stb),
        .tog_out   (tog_out)
    );

    task automatic check(input string req);
        checks++;
        if (rd_data !== m_reg || tog_out !== m_tog) begin
            fails++;
            $display("FAIL %s: rd_data=%02h tog_out=%b, expected rd_data=%02h tog_out=%b",
                     req, rd_data, tog_out, m_reg, m_tog);
        end
    endtask

    // Check at the falling edge, then drive one cycle of stimulus and update the model.
    task automatic step(input logic f, input logic l, input logic w,
                        input logic [7:0] d, input string req);
        @(negedge clk);
        check(req);
        frame_stb = f;
        line_stb  = l;
        wr_en     = w;
        wr_data   = d;
        if (w) begin
            m_reg = d;
            m_cnt = 0;
        end else if (m_reg[7] ? l : f) begin
            if (m_cnt == int'(m_reg[6:0])) begin
                m_cnt = 0;
                m_tog = ~m_tog;
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, 1'b0, 8'h00, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        idle("R1");
        idle("R1");

        // R5 and R3: sweep every code with frame strobes, with line noise in between
        for (int c = 0; c < 128; c++) begin
            step(1'b0, 1'b0, 1'b1, 8'(c), "R2");
            for (int k = 0; k < 2 * (c + 1) + 3; k++) begin
                step(1'b1, 1'b0, 1'b0, 8'h00, "R5");
                step(1'b0, 1'b1, 1'b0, 8'h00, "R3");
            end
        end

        // R4: line source on several codes, frame strobes ignored
        for (int c = 0; c < 128; c += 9) begin
            step(1'b0, 1'b0, 1'b1, 8'h80 | 8'(c), "R2");
            for (int k = 0; k < 2 * (c + 1) + 2; k++) begin
                step(1'b0, 1'b1, 1'b0, 8'h00, "R4");
                step(1'b1, 1'b0, 1'b0, 8'h00, "R4");
                step(1'b1, 1'b1, 1'b0, 8'h00, "R4");
            end
        end

        // R6: a write in mid-count clears the count, and a strobe with the write is dropped
        step(1'b0, 1'b0, 1'b1, 8'h03, "R2");
        step(1'b1, 1'b0, 1'b0, 8'h00, "R6");
        step(1'b1, 1'b0, 1'b0, 8'h00, "R6");
        step(1'b1, 1'b0, 1'b1, 8'h03, "R6");
        for (int k = 0; k < 9; k++) step(1'b1, 1'b0, 1'b0, 8'h00, "R6");
        idle("R6");

        // R8: switch source in mid-count, new source counts from the next strobe
        step(1'b0, 1'b0, 1'b1, 8'h02, "R2");
        step(1'b1, 1'b0, 1'b0, 8'h00, "R8");
        step(1'b0, 1'b0, 1'b1, 8'h82, "R8");
        step(1'b1, 1'b0, 1'b0, 8'h00, "R8");
        for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 1'b0, 8'h00, "R8");
        idle("R8");

        // R7: back-to-back strobes with code 0, then a quiet stretch
        step(1'b0, 1'b0, 1'b1, 8'h00, "R2");
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b0, 8'h00, "R7");
        for (int k = 0; k < 6; k++) idle("R7");

        // R2: arbitrary readback patterns
        step(1'b0, 1'b0, 1'b1, 8'hA5, "R2");
        step(1'b0, 1'b0, 1'b1, 8'h5A, "R2");
        step(1'b0, 1'b0, 1'b1, 8'hFF, "R2");
        idle("R2");

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        m_reg = '0;
        m_cnt = 0;
        m_tog = 1'b0;
        wr_en = 1'b0;
        frame_stb = 1'b0;
        line_stb = 1'b0;
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        idle("R1");
        idle("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule